// File: doc/BRIEF.md
# Dual-Port Shared Memory Access Controller

This block is a word-addressed shared memory with two fully independent ports, left and right. Each port carries its own pair of chip selects of opposite polarity, a write strobe, an output-enable, a flag-space select, an address and byte-wide write and read data. Every clock cycle each port's controls are decoded into one of four modes: idle (deselected), write, read, or quiet (outputs released). The block then performs the access and drives or releases that port's modelled three-state read bus.

A port is selected only when its active-low select is low and its active-high select is high. Two devices can therefore share one address space with no outside decode: one receives an address bit on its active-high select, the other on its active-low select. The tri-state bus is modelled as a read-data vector plus a drive flag. Reads are registered, so data appears one cycle after the address. Writes land on the rising edge. Every access completes in that same cycle, so a port has no back-pressure and no handshake. The address width is a parameter: 16 bits at full size, with a smaller default.

Same-address collisions follow fixed rules. If both ports write one word in the same cycle, the left port's data is kept. A port that reads a word while the other port writes it receives the value from before the write.

Top module: `dpram_ctrl`

## Requirements
- R1: A port is selected only when its `*_cs_n` is 0 and its `*_cs` is 1. Under any other combination that port writes nothing, and one cycle later its `*_drive` is 0.
- R2: A selected port with `*_wr_n` = 0 and `*_flag_n` = 1 stores `*_wdata` at `*_addr` on the rising edge, whatever the level of `*_outen_n`.
- R3: A selected port with `*_wr_n` = 1, `*_outen_n` = 0 and `*_flag_n` = 1 presents the stored word on `*_rdata`, with `*_drive` = 1, in the cycle after the address is sampled.
- R4: `*_outen_n` = 1 makes `*_drive` 0 in the following cycle, whatever the other inputs are.
- R5: `*_flag_n` = 0 blocks all memory access for that port: no write takes place, and `*_drive` is 0 in the following cycle.
- R6: Whenever `*_drive` is 0, `*_rdata` is all zeros.
- R7: Both ports may read the same address in the same cycle, and both receive the stored word.
- R8: When both ports write the same address in the same cycle, the left port's data is stored.
- R9: A port that reads an address while the other port writes it in the same cycle receives the old word. A later read returns the new word.
- R10: After reset, both `*_drive` outputs are 0 and both `*_rdata` buses are all zeros.
- R11: Writes from the two ports to different addresses in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all accesses occur on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the read stages |
| lft_cs_n | input | 1 | Left active-low chip select |
| lft_cs | input | 1 | Left active-high chip select |
| lft_wr_n | input | 1 | Left write strobe, 0 = write, 1 = read |
| lft_outen_n | input | 1 | Left active-low output enable |
| lft_flag_n | input | 1 | Left flag-space select, 0 blocks memory access |
| lft_addr | input | ADDR_W | Left word address |
| lft_wdata | input | DATA_W | Left write data |
| lft_rdata | output | DATA_W | Left read data, zero when released |
| lft_drive | output | 1 | Left bus drive flag, 1 = driven, 0 = high-Z |
| rgt_cs_n | input | 1 | Right active-low chip select |
| rgt_cs | input | 1 | Right active-high chip select |
| rgt_wr_n | input | 1 | Right write strobe, 0 = write, 1 = read |
| rgt_outen_n | input | 1 | Right active-low output enable |
| rgt_flag_n | input | 1 | Right flag-space select, 0 blocks memory access |
| rgt_addr | input | ADDR_W | Right word address |
| rgt_wdata | input | DATA_W | Right write data |
| rgt_rdata | output | DATA_W | Right read data, zero when released |
| rgt_drive | output | 1 | Right bus drive flag, 1 = driven, 0 = high-Z |

## Verification
A wrong mode decode shows within one cycle. It appears either as a drive flag raised where the bus should be released, or as a missing read word in the cycle after a valid read. A corrupted or misdirected write stays hidden in the storage until a later read of that address. The bench therefore follows every write scenario, including the blocked ones and both collision orders, with a read-back on each port. Data from a wrong port surfaces only on a collision, so a same-address write pair and a write-under-read pair are each read back one cycle later.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  localparam int NPORTS = 2;
  localparam int LEFT   = 0;
  localparam int RIGHT  = 1;

  // Per-port access mode resolved each cycle from the control pins.
  typedef enum logic [1:0] {
    PM_IDLE  = 2'd0,  // deselected or flag space: no memory access
    PM_WRITE = 2'd1,  // store write data at address
    PM_READ  = 2'd2,  // fetch word, drive bus next cycle
    PM_QUIET = 2'd3   // output enable inactive: bus released
  } pm_t;

  typedef struct packed {
    logic cs_n;
    logic cs;
    logic wr_n;
    logic outen_n;
    logic flag_n;
  } port_ctl_t;

endpackage

// File: rtl/dpram_port_decode.sv
module dpram_port_decode
  import dpram_pkg::*;
(
  input  port_ctl_t ctl,
  output pm_t       mode,
  output logic      wr_go,
  output logic      rd_go
);

  logic selected;
  logic mem_space;

  always_comb begin
    selected  = (ctl.cs_n == 1'b0) && (ctl.cs == 1'b1);
    mem_space = selected && ctl.flag_n;
    if (mem_space && !ctl.wr_n)
      mode = PM_WRITE;
    else if (ctl.outen_n)
      mode = PM_QUIET;
    else if (mem_space)
      mode = PM_READ;
    else
      mode = PM_IDLE;
  end

  assign wr_go = (mode == PM_WRITE);
  assign rd_go = (mode == PM_READ);

endmodule

// File: rtl/dpram_store.sv
module dpram_store
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic [NPORTS-1:0] wr_go,
  input  logic [ADDR_W-1:0] addr  [NPORTS],
  input  logic [DATA_W-1:0] wdata [NPORTS],
  output logic [DATA_W-1:0] word  [NPORTS]
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Ports are visited from the highest index down so the left port,
  // index 0, makes the last nonblocking update and wins a collision.
  always_ff @(posedge clk) begin
    for (int p = NPORTS - 1; p >= 0; p--) begin
      if (wr_go[p])
        mem[addr[p]] <= wdata[p];
    end
  end

  // Combinational fetch; the read stage samples it at the same edge
  // that commits writes, so a same-cycle reader sees the old word.
  for (genvar g = 0; g < NPORTS; g++) begin : g_fetch
    assign word[g] = mem[addr[g]];
  end

endmodule

// File: rtl/dpram_rd_stage.sv
module dpram_rd_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_go,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] rdata,
  output logic              drive
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      drive <= 1'b0;
    end else if (rd_go) begin
      rdata <= word;
      drive <= 1'b1;
    end else begin
      rdata <= '0;
      drive <= 1'b0;
    end
  end

endmodule

// File: rtl/dpram_ctrl.sv
module dpram_ctrl
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lft_cs_n,
  input  logic              lft_cs,
  input  logic              lft_wr_n,
  input  logic              lft_outen_n,
  input  logic              lft_flag_n,
  input  logic [ADDR_W-1:0] lft_addr,
  input  logic [DATA_W-1:0] lft_wdata,
  output logic [DATA_W-1:0] lft_rdata,
  output logic              lft_drive,
  input  logic              rgt_cs_n,
  input  logic              rgt_cs,
  input  logic              rgt_wr_n,
  input  logic              rgt_outen_n,
  input  logic              rgt_flag_n,
  input  logic [ADDR_W-1:0] rgt_addr,
  input  logic [DATA_W-1:0] rgt_wdata,
  output logic [DATA_W-1:0] rgt_rdata,
  output logic              rgt_drive
);

  port_ctl_t         ctl   [NPORTS];
  pm_t               mode  [NPORTS];
  logic [NPORTS-1:0] wr_go;
  logic [NPORTS-1:0] rd_go;
  logic [ADDR_W-1:0] addr  [NPORTS];
  logic [DATA_W-1:0] wdata [NPORTS];
  logic [DATA_W-1:0] word  [NPORTS];
  logic [DATA_W-1:0] rdata [NPORTS];
  logic [NPORTS-1:0] drive;

  assign ctl[LEFT]   = '{cs_n: lft_cs_n, cs: lft_cs, wr_n: lft_wr_n,
                         outen_n: lft_outen_n, flag_n: lft_flag_n};
  assign ctl[RIGHT]  = '{cs_n: rgt_cs_n, cs: rgt_cs, wr_n: rgt_wr_n,
                         outen_n: rgt_outen_n, flag_n: rgt_flag_n};
  assign addr[LEFT]  = lft_addr;
  assign addr[RIGHT] = rgt_addr;
  assign wdata[LEFT]  = lft_wdata;
  assign wdata[RIGHT] = rgt_wdata;

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    dpram_port_decode u_dec (
      .ctl   (ctl[g]),
      .mode  (mode[g]),
      .wr_go (wr_go[g]),
      .rd_go (rd_go[g])
    );

    dpram_rd_stage #(.DATA_W(DATA_W)) u_rd (
      .clk   (clk),
      .rst_n (rst_n),
      .rd_go (rd_go[g]),
      .word  (word[g]),
      .rdata (rdata[g]),
      .drive (drive[g])
    );
  end

  dpram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .wr_go (wr_go),
    .addr  (addr),
    .wdata (wdata),
    .word  (word)
  );

  assign lft_rdata = rdata[LEFT];
  assign lft_drive = drive[LEFT];
  assign rgt_rdata = rdata[RIGHT];
  assign rgt_drive = drive[RIGHT];

endmodule

// File: rtl/dpram_ctrl_chk.sv
module dpram_ctrl_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lft_cs_n,
  input logic              lft_cs,
  input logic              lft_wr_n,
  input logic              lft_outen_n,
  input logic              lft_flag_n,
  input logic [ADDR_W-1:0] lft_addr,
  input logic [DATA_W-1:0] lft_rdata,
  input logic              lft_drive,
  input logic              rgt_cs_n,
  input logic              rgt_cs,
  input logic              rgt_wr_n,
  input logic              rgt_outen_n,
  input logic              rgt_flag_n,
  input logic [ADDR_W-1:0] rgt_addr,
  input logic [DATA_W-1:0] rgt_rdata,
  input logic              rgt_drive
);

  logic lft_rd_req, rgt_rd_req;
  assign lft_rd_req = !lft_cs_n && lft_cs && lft_wr_n && !lft_outen_n && lft_flag_n;
  assign rgt_rd_req = !rgt_cs_n && rgt_cs && rgt_wr_n && !rgt_outen_n && rgt_flag_n;

  // R1
  lft_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lft_cs_n || !lft_cs) |=> !lft_drive);
  // R1
  rgt_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rgt_cs_n || !rgt_cs) |=> !rgt_drive);
  // R3
  lft_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lft_rd_req |=> lft_drive);
  // R3
  rgt_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rgt_rd_req |=> rgt_drive);
  // R4
  lft_outen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lft_outen_n |=> !lft_drive);
  // R4
  rgt_outen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rgt_outen_n |=> !rgt_drive);
  // R5
  lft_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lft_flag_n |=> !lft_drive);
  // R5
  rgt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rgt_flag_n |=> !rgt_drive);
  // R6
  lft_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lft_drive |-> (lft_rdata == '0));
  // R6
  rgt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rgt_drive |-> (rgt_rdata == '0));
  // R7
  dual_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lft_rd_req && rgt_rd_req && lft_addr == rgt_addr) |=> (lft_rdata == rgt_rdata));

endmodule

bind dpram_ctrl dpram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_dpram_ctrl.sv
`timescale 1ns/1ps
module sim_dpram_ctrl;

  localparam int AW = 6;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lft_cs_n, lft_cs, lft_wr_n, lft_outen_n, lft_flag_n;
  logic [AW-1:0] lft_addr;
  logic [DW-1:0] lft_wdata, lft_rdata;
  logic          lft_drive;
  logic          rgt_cs_n, rgt_cs, rgt_wr_n, rgt_outen_n, rgt_flag_n;
  logic [AW-1:0] rgt_addr;
  logic [DW-1:0] rgt_wdata, rgt_rdata;
  logic          rgt_drive;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dpram_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u0 (.*);

  // ---- driving helpers ----
  task automatic l_set(input logic cs_n, cs, wr_n, outen_n, flag_n,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    lft_cs_n = cs_n; lft_cs = cs; lft_wr_n = wr_n;
    lft_outen_n = outen_n; lft_flag_n = flag_n; lft_addr = a; lft_wdata = d;
  endtask

  task automatic r_set(input logic cs_n, cs, wr_n, outen_n, flag_n,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    rgt_cs_n = cs_n; rgt_cs = cs; rgt_wr_n = wr_n;
    rgt_outen_n = outen_n; rgt_flag_n = flag_n; rgt_addr = a; rgt_wdata = d;
  endtask

  task automatic l_idle(); l_set(1, 0, 1, 1, 1, '0, '0); endtask
  task automatic r_idle(); r_set(1, 0, 1, 1, 1, '0, '0); endtask
  task automatic l_wr(input logic [AW-1:0] a, input logic [DW-1:0] d); l_set(0, 1, 0, 1, 1, a, d); endtask
  task automatic r_wr(input logic [AW-1:0] a, input logic [DW-1:0] d); r_set(0, 1, 0, 1, 1, a, d); endtask
  task automatic l_rd(input logic [AW-1:0] a); l_set(0, 1, 1, 0, 1, a, '0); endtask
  task automatic r_rd(input logic [AW-1:0] a); r_set(0, 1, 1, 0, 1, a, '0); endtask

  // Inputs change at a falling edge; one rising edge later the result
  // is visible, sampled at the next falling edge.
  task automatic step(); @(negedge clk); endtask

  task automatic check(input string req, input logic [DW:0] got, input logic [DW:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic l_expect(input string req, input logic drv, input logic [DW-1:0] d);
    check(req, {lft_drive, lft_rdata}, {drv, d});
  endtask
  task automatic r_expect(input string req, input logic drv, input logic [DW-1:0] d);
    check(req, {rgt_drive, rgt_rdata}, {drv, d});
  endtask

  // ---- scenarios ----
  task automatic t_reset();
    l_expect("R10 left after reset", 0, 8'h00);
    r_expect("R10 right after reset", 0, 8'h00);
  endtask

  task automatic t_write_read();
    l_wr(6'd5, 8'h3C); r_idle(); step();
    l_rd(6'd5); step();
    l_expect("R2/R3 left read back", 1, 8'h3C);
    l_rd(6'd5); r_rd(6'd5); step();
    l_expect("R7 left dual read", 1, 8'h3C);
    r_expect("R7 right dual read", 1, 8'h3C);
    l_idle(); r_idle(); step();
    l_expect("R6 left released", 0, 8'h00);
  endtask

  task automatic t_select();
    l_set(0, 0, 0, 1, 1, 6'd5, 8'hFF); step();
    l_expect("R1 both selects low", 0, 8'h00);
    l_set(1, 1, 0, 1, 1, 6'd5, 8'hEE); step();
    l_set(1, 0, 1, 0, 1, 6'd5, 8'h00); step();
    l_expect("R1 deselected read releases", 0, 8'h00);
    r_rd(6'd5); l_idle(); step();
    r_expect("R1 deselected writes ignored", 1, 8'h3C);
    r_idle(); step();
  endtask

  task automatic t_outen();
    r_set(0, 1, 0, 0, 1, 6'd7, 8'h5A); step();  // write with output enable low
    r_set(0, 1, 1, 1, 1, 6'd7, 8'h00); step();
    r_expect("R4 output enable high releases", 0, 8'h00);
    r_set(0, 1, 0, 1, 1, 6'd8, 8'h66); step();  // write with output enable high
    r_rd(6'd7); step();
    r_expect("R2 write with output enable low", 1, 8'h5A);
    r_rd(6'd8); step();
    r_expect("R2 write with output enable high", 1, 8'h66);
    r_idle(); step();
  endtask

  task automatic t_flag();
    l_set(0, 1, 0, 1, 0, 6'd5, 8'h99); step();
    l_set(0, 1, 1, 0, 0, 6'd5, 8'h00); step();
    l_expect("R5 flag space read released", 0, 8'h00);
    l_rd(6'd5); step();
    l_expect("R5 flag space write blocked", 1, 8'h3C);
    l_idle(); step();
  endtask

  task automatic t_collide_ww();
    l_wr(6'd9, 8'hAA); r_wr(6'd9, 8'h55); step();
    l_rd(6'd9); r_rd(6'd9); step();
    l_expect("R8 left wins collision (left view)", 1, 8'hAA);
    r_expect("R8 left wins collision (right view)", 1, 8'hAA);
    l_idle(); r_idle(); step();
  endtask

  task automatic t_read_under_write();
    l_wr(6'd12, 8'h11); step();
    l_wr(6'd12, 8'h22); r_rd(6'd12); step();
    r_expect("R9 right reads old word", 1, 8'h11);
    l_idle(); r_rd(6'd12); step();
    r_expect("R9 right reads new word", 1, 8'h22);
    r_wr(6'd13, 8'h44); l_idle(); step();
    r_wr(6'd13, 8'h77); l_rd(6'd13); step();
    l_expect("R9 left reads old word", 1, 8'h44);
    r_idle(); l_rd(6'd13); step();
    l_expect("R9 left reads new word", 1, 8'h77);
    l_idle(); step();
  endtask

  task automatic t_indep();
    l_wr(6'd20, 8'h01); r_wr(6'd63, 8'h02); step();
    l_rd(6'd63); r_rd(6'd20); step();
    l_expect("R11 left sees right write", 1, 8'h02);
    r_expect("R11 right sees left write", 1, 8'h01);
    l_idle(); r_idle(); step();
  endtask

  initial begin
    l_idle(); r_idle();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    t_write_read();
    t_select();
    t_outen();
    t_flag();
    t_collide_ww();
    t_read_under_write();
    t_indep();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule